// File: doc/BRIEF.md
# Frequency-Select Latch and Clock Ratio Decoder

This block decides which 5-bit frequency code is active and turns it into the divide ratios of the derived clock groups. It produces a host clock, a half-rate host clock, a 66-class clock, a PCI-class clock and an APIC-class clock. The code comes from one of two places. The first is a set of strap inputs, captured once after reset. The second is a software control byte, which is used when that byte's override bit is set. Every code falls into one of two ratio families. In the thirds family, the 66-class clock runs at 2/3 of the host clock, PCI at 1/3 and APIC at 1/6. In the quarters family, the 66-class clock runs at 1/2 of the host clock, PCI at 1/4 and APIC at 1/8.

All outputs are built by counter dividers from one fast base clock. In the base clock, the host half-period is `HOST_HALF` cycles (an even number), so every ratio keeps a 50% duty cycle. A frame counter spans the least common multiple of all periods in the current family. A new code, and with it a new family, is loaded only at a frame boundary. At that edge every divider restarts high together, so a change of code never produces a runt pulse. A separate divider drives a selectable 48/24 output. Its select is sampled at the output's own frame boundary.

Top module: `fsel_ratio_gen`

## Requirements
- R1: When `cfg_byte[3]` is 1, the code is {`cfg_byte[2]`, `cfg_byte[7]`, `cfg_byte[6]`, `cfg_byte[5]`, `cfg_byte[4]`}, from MSB to LSB. It appears on `act_code` at the next frame boundary.
- R2: When `cfg_byte[3]` is 0, the code is the value of `strap_fs` sampled on the first clock edge after reset release. Later changes on `strap_fs` have no effect until the next reset.
- R3: While `rst_n` is low, every clock output, `act_code` and `fam_quarters` are 0.
- R4: On the second clock edge after reset release, all five group clocks rise together. From then on, `host_clk` has a period of 2*HOST_HALF base cycles and `host_div2_clk` has exactly twice that period, both at 50% duty.
- R5: Codes 0x00–0x09 and 0x0B–0x10 use the thirds family (`fam_quarters`=0). The half-periods of mid, PCI and APIC are 1.5, 3 and 6 times HOST_HALF.
- R6: Code 0x0A and codes 0x11–0x1F use the quarters family (`fam_quarters`=1). The half-periods of mid, PCI and APIC are 2, 4 and 8 times HOST_HALF.
- R7: `act_code` and the family change only at an edge where all group clocks rise together. Every high or low phase of every group clock lasts exactly one half-period of the old family or of the new one.
- R8: `usb_clk` has a half-period of USB_HALF base cycles (48 MHz mode) when `usb_sel` is 0, and 2*USB_HALF (24 MHz mode) when it is 1.
- R9: A change of `usb_sel` takes effect only at a rising edge of `usb_clk`. Every `usb_clk` phase lasts USB_HALF or 2*USB_HALF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Fast base clock driving all dividers |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 5 | Frequency strap pins (pulled up, so open pins read 1) |
| cfg_byte | input | 6 | Bits 7..2 of the software control byte |
| usb_sel | input | 1 | 0 selects 48 MHz mode, 1 selects 24 MHz mode |
| host_clk | output | 1 | Host clock |
| host_div2_clk | output | 1 | Half-rate host clock |
| mid_clk | output | 1 | 66-class clock |
| pci_clk | output | 1 | PCI-class clock |
| apic_clk | output | 1 | APIC-class clock |
| usb_clk | output | 1 | Selectable 48/24 clock |
| act_code | output | 5 | Frequency code currently applied |
| fam_quarters | output | 1 | 1 when the quarters ratio family is active |

## Verification
The bench aims at the two isolated family members: code 0x0A, which sits inside the thirds range, and code 0x10, which sits just below the quarters range. A decoder built on a simple threshold would give both of them the wrong ratios, and the measured periods would show it. The bench also watches every pulse of every output while codes and the 48/24 select change mid-frame. A design that loads the new ratio at once would produce a phase length that belongs to neither family. Finally, the bench changes the straps after reset and then resets again. A design that keeps tracking the pins would change `act_code` in the middle of a run.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    localparam int CODE_W = 5;
    localparam int NDIV   = 5;   // host, host/2, mid, pci, apic

    typedef enum logic {
        FAM_THIRDS   = 1'b0,
        FAM_QUARTERS = 1'b1
    } fam_e;

    // Two isolated quarter-family members: one inside the low range, and the whole upper run
    function automatic fam_e code_family(input logic [CODE_W-1:0] c);
        return (c == 5'h0A || c >= 5'h11) ? FAM_QUARTERS : FAM_THIRDS;
    endfunction
endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
    import fsel_pkg::*;
#(
    parameter int HOST_HALF = 2,
    parameter int DW        = 5,
    parameter int PW        = 5
) (
    input  logic [CODE_W-1:0] code,
    output fam_e              fam,
    output logic [DW-1:0]     half_mid,
    output logic [DW-1:0]     half_pci,
    output logic [DW-1:0]     half_apic,
    output logic [PW-1:0]     frame_last
);
    localparam int T_MID   = (3 * HOST_HALF) / 2;
    localparam int T_PCI   = 3 * HOST_HALF;
    localparam int T_APIC  = 6 * HOST_HALF;
    localparam int T_FRAME = 12 * HOST_HALF;
    localparam int Q_MID   = 2 * HOST_HALF;
    localparam int Q_PCI   = 4 * HOST_HALF;
    localparam int Q_APIC  = 8 * HOST_HALF;
    localparam int Q_FRAME = 16 * HOST_HALF;

    always_comb begin
        fam = code_family(code);
        if (fam == FAM_QUARTERS) begin
            half_mid   = DW'(Q_MID);
            half_pci   = DW'(Q_PCI);
            half_apic  = DW'(Q_APIC);
            frame_last = PW'(Q_FRAME - 1);
        end else begin
            half_mid   = DW'(T_MID);
            half_pci   = DW'(T_PCI);
            half_apic  = DW'(T_APIC);
            frame_last = PW'(T_FRAME - 1);
        end
    end
endmodule

// File: rtl/fsel_div.sv
module fsel_div #(
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [DW-1:0] half,
    output logic          clk_out
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          lvl;
    } div_t;

    div_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.cnt = '0;
            d.lvl = 1'b1;
        end else if (run) begin
            if (q.cnt == half - 1'b1) begin
                d.cnt = '0;
                d.lvl = ~q.lvl;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign clk_out = q.lvl;
endmodule

// File: rtl/fsel_ratio_gen.sv
module fsel_ratio_gen
    import fsel_pkg::*;
#(
    parameter int HOST_HALF = 2,
    parameter int USB_HALF  = 3
) (
    input  logic              clk_base,
    input  logic              rst_n,
    input  logic [4:0]        strap_fs,
    input  logic [7:2]        cfg_byte,
    input  logic              usb_sel,
    output logic              host_clk,
    output logic              host_div2_clk,
    output logic              mid_clk,
    output logic              pci_clk,
    output logic              apic_clk,
    output logic              usb_clk,
    output logic [4:0]        act_code,
    output logic              fam_quarters
);
    localparam int MAXH = (8 * HOST_HALF > 2 * USB_HALF) ? 8 * HOST_HALF : 2 * USB_HALF;
    localparam int DW   = $clog2(MAXH + 1);
    localparam int PW   = $clog2(16 * HOST_HALF);
    localparam int UPW  = $clog2(4 * USB_HALF);

    typedef struct packed {
        logic [CODE_W-1:0] strap;
        logic              vld;
        logic              live;
        logic [CODE_W-1:0] code;
        logic [PW-1:0]     phase;
        logic              usel;
        logic              ulive;
        logic [UPW-1:0]    uphase;
    } seq_t;

    seq_t q, d;

    fam_e          fam;
    logic [DW-1:0] half_mid, half_pci, half_apic;
    logic [PW-1:0] frame_last;
    logic [CODE_W-1:0] sel_code;
    logic          restart, urestart;
    logic [DW-1:0] div_half [NDIV];
    logic [NDIV-1:0] div_out;
    logic [DW-1:0] usb_half;

    fsel_decode #(.HOST_HALF(HOST_HALF), .DW(DW), .PW(PW)) u_dec (
        .code       (q.code),
        .fam        (fam),
        .half_mid   (half_mid),
        .half_pci   (half_pci),
        .half_apic  (half_apic),
        .frame_last (frame_last)
    );

    always_comb begin
        sel_code = cfg_byte[3] ? {cfg_byte[2], cfg_byte[7:4]} : q.strap;
        restart  = q.vld && (!q.live  || q.phase  == frame_last);
        urestart = q.vld && (!q.ulive || q.uphase == UPW'(4 * USB_HALF - 1));

        d = q;
        if (!q.vld) begin
            d.strap = strap_fs;
            d.vld   = 1'b1;
        end
        if (restart) begin
            d.code  = sel_code;
            d.phase = '0;
            d.live  = 1'b1;
        end else if (q.live) begin
            d.phase = q.phase + 1'b1;
        end
        if (urestart) begin
            d.usel   = usb_sel;
            d.uphase = '0;
            d.ulive  = 1'b1;
        end else if (q.ulive) begin
            d.uphase = q.uphase + 1'b1;
        end

        div_half[0] = DW'(HOST_HALF);
        div_half[1] = DW'(2 * HOST_HALF);
        div_half[2] = half_mid;
        div_half[3] = half_pci;
        div_half[4] = half_apic;
        usb_half    = q.usel ? DW'(2 * USB_HALF) : DW'(USB_HALF);
    end

    always_ff @(posedge clk_base or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        fsel_div #(.DW(DW)) u_div (
            .clk     (clk_base),
            .rst_n   (rst_n),
            .run     (q.live),
            .restart (restart),
            .half    (div_half[g]),
            .clk_out (div_out[g])
        );
    end

    fsel_div #(.DW(DW)) u_usb_div (
        .clk     (clk_base),
        .rst_n   (rst_n),
        .run     (q.ulive),
        .restart (urestart),
        .half    (usb_half),
        .clk_out (usb_clk)
    );

    assign host_clk      = div_out[0];
    assign host_div2_clk = div_out[1];
    assign mid_clk       = div_out[2];
    assign pci_clk       = div_out[3];
    assign apic_clk      = div_out[4];
    assign act_code      = q.code;
    assign fam_quarters  = (fam == FAM_QUARTERS);
endmodule

// File: rtl/fsel_ratio_gen_chk.sv
module fsel_ratio_gen_chk (
    input logic       clk_base,
    input logic       rst_n,
    input logic       host_clk,
    input logic       host_div2_clk,
    input logic       mid_clk,
    input logic       pci_clk,
    input logic       apic_clk,
    input logic [4:0] act_code,
    input logic       fam_quarters
);
    // R4
    div2_aligned_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
        $rose(host_div2_clk) |-> $rose(host_clk));

    // R5
    apic_aligned_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
        $rose(apic_clk) |-> ($rose(pci_clk) && $rose(mid_clk) && $rose(host_clk)));

    // R7
    code_switch_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
        !$stable(act_code) |-> ($rose(host_clk) && $rose(mid_clk)));

    // R6
    fam_switch_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
        !$stable(fam_quarters) |-> $rose(apic_clk));

    // R3
    reset_low_chk: assert property (@(posedge clk_base)
        !rst_n |-> (!host_clk && !apic_clk && act_code == 5'h00));
endmodule

bind fsel_ratio_gen fsel_ratio_gen_chk u_chk (
    .clk_base      (clk_base),
    .rst_n         (rst_n),
    .host_clk      (host_clk),
    .host_div2_clk (host_div2_clk),
    .mid_clk       (mid_clk),
    .pci_clk       (pci_clk),
    .apic_clk      (apic_clk),
    .act_code      (act_code),
    .fam_quarters  (fam_quarters)
);

// File: tb/fsel_ratio_gen_tb.sv
`timescale 1ns/1ps
module fsel_ratio_gen_tb;
    localparam int HH = 2;
    localparam int UH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap_fs = 5'h1F;
    logic [7:2] cfg_byte = '0;
    logic       usb_sel = 1'b0;
    logic       host_clk, host_div2_clk, mid_clk, pci_clk, apic_clk, usb_clk;
    logic [4:0] act_code;
    logic       fam_quarters;

    always #2 clk = ~clk;

    fsel_ratio_gen #(.HOST_HALF(HH), .USB_HALF(UH)) u_dut (
        .clk_base(clk), .rst_n(rst_n), .strap_fs(strap_fs), .cfg_byte(cfg_byte),
        .usb_sel(usb_sel), .host_clk(host_clk), .host_div2_clk(host_div2_clk),
        .mid_clk(mid_clk), .pci_clk(pci_clk), .apic_clk(apic_clk), .usb_clk(usb_clk),
        .act_code(act_code), .fam_quarters(fam_quarters)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // {cfg_byte[7:2], expected code, expected quarters flag}
    localparam logic [11:0] VEC [8] = '{
        {6'h02, 5'h00, 1'b0},
        {6'h2A, 5'h0A, 1'b1},
        {6'h26, 5'h09, 1'b0},
        {6'h2E, 5'h0B, 1'b0},
        {6'h03, 5'h10, 1'b0},
        {6'h07, 5'h11, 1'b1},
        {6'h3F, 5'h1F, 1'b1},
        {6'h16, 5'h05, 1'b0}
    };

    task automatic chk(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // pulse monitor: index 0 host, 1 div2, 2 mid, 3 pci, 4 apic, 5 usb
    logic [5:0] lv, lv_prev;
    int run_len [6], trans [6], last_rise [6], per [6], hi [6];
    int cyc = 0;
    assign lv = {usb_clk, apic_clk, pci_clk, mid_clk, host_div2_clk, host_clk};

    function automatic bit allowed(input int i, input int dur);
        case (i)
            0: return dur == HH;
            1: return dur == 2 * HH;
            2: return dur == 3 * HH / 2 || dur == 2 * HH;
            3: return dur == 3 * HH || dur == 4 * HH;
            4: return dur == 6 * HH || dur == 8 * HH;
            default: return dur == UH || dur == 2 * UH;
        endcase
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin
                run_len[i] = 0; trans[i] = 0;
            end
            lv_prev = '0;
        end else begin
            for (int i = 0; i < 6; i++) begin
                if (lv[i] != lv_prev[i]) begin
                    if (trans[i] > 0) begin
                        n_chk++;
                        if (!allowed(i, run_len[i])) begin
                            n_bad++;
                            $display("FAIL R7/R9 output %0d: phase of %0d cycles expected a family half-period",
                                     i, run_len[i]);
                        end
                    end
                    if (lv[i]) begin
                        per[i] = cyc - last_rise[i];
                        last_rise[i] = cyc;
                    end else begin
                        hi[i] = run_len[i];
                    end
                    trans[i]++;
                    run_len[i] = 1;
                end else begin
                    run_len[i]++;
                end
            end
            lv_prev = lv;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk_ratios(input bit q, input string tag);
        chk(per[0], 2 * HH, {tag, " R4 host period"});
        chk(hi[0], HH, {tag, " R4 host high"});
        chk(per[1], 4 * HH, {tag, " R4 div2 period"});
        chk(hi[1], 2 * HH, {tag, " R4 div2 high"});
        chk(per[2], q ? 4 * HH : 3 * HH, {tag, " R5/R6 mid period"});
        chk(per[3], q ? 8 * HH : 6 * HH, {tag, " R5/R6 pci period"});
        chk(hi[3], q ? 4 * HH : 3 * HH, {tag, " R5/R6 pci high"});
        chk(per[4], q ? 16 * HH : 12 * HH, {tag, " R5/R6 apic period"});
        chk(hi[4], q ? 8 * HH : 6 * HH, {tag, " R5/R6 apic high"});
    endtask

    initial begin
        wait_cyc(5);
        // R3 reset state
        chk(int'(lv), 0, "R3 clocks low in reset");
        chk(act_code, 0, "R3 code zero in reset");
        rst_n = 1'b1;           // released away from the edge
        wait_cyc(1);
        chk(int'(lv), 0, "R4 still low after first edge");
        wait_cyc(1);
        chk(int'(lv[4:0]), 5'h1F, "R4 common rise on second edge");
        chk(act_code, 5'h1F, "R2 open straps read all ones");
        chk(fam_quarters, 1, "R6 code 0x1F quarters");
        wait_cyc(140);
        chk_ratios(1'b1, "strap 0x1F");

        // software-selected codes, including boundary codes
        for (int v = 0; v < 8; v++) begin
            cfg_byte = VEC[v][11:6];
            wait_cyc(140);
            chk(act_code, int'(VEC[v][5:1]), $sformatf("R1 code vec %0d", v));
            chk(fam_quarters, int'(VEC[v][0]), $sformatf("R5/R6 family vec %0d", v));
            chk_ratios(VEC[v][0], $sformatf("vec %0d", v));
        end

        // R2: back to straps, later strap change ignored
        cfg_byte = '0;
        wait_cyc(100);
        chk(act_code, 5'h1F, "R2 strap code restored");
        strap_fs = 5'h03;
        wait_cyc(100);
        chk(act_code, 5'h1F, "R2 strap change ignored");
        chk(fam_quarters, 1, "R2 family unchanged");

        // R8/R9 selectable output
        usb_sel = 1'b1;
        wait_cyc(60);
        chk(per[5], 4 * UH, "R8 24 MHz mode period");
        chk(hi[5], 2 * UH, "R8 24 MHz mode high");
        usb_sel = 1'b0;
        wait_cyc(60);
        chk(per[5], 2 * UH, "R8 48 MHz mode period");
        chk(hi[5], UH, "R8 48 MHz mode high");

        // R3/R2: reset again captures new straps
        rst_n = 1'b0;
        wait_cyc(3);
        chk(int'(lv), 0, "R3 clocks low in second reset");
        rst_n = 1'b1;
        wait_cyc(140);
        chk(act_code, 5'h03, "R2 new straps after reset");
        chk(fam_quarters, 0, "R5 code 0x03 thirds");
        chk_ratios(1'b0, "strap 0x03");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule